// File: doc/BRIEF.md
# Keyed Register Write Guard

This block sits beside the configuration registers of a peripheral and decides, cycle by cycle, whether a write on the register bus may land. It owns two registers of its own. The guard control register, at offset 0xE4, holds a single protect-enable bit. That bit only changes when the same write carries a fixed 24-bit key in its upper bits. The guard status register, at offset 0xE8, records the most recent write that protection refused.

For every bus write, the block raises one bit of a per-word write-allow vector. The peripheral's registers use that vector as their write enable. When protection is on and the target is in the protected set, the allow bit stays low. The refusal is then logged with the targeted offset. The protected set is a parameter: a list of byte offsets.

The bus has separate write and read addresses, so a refused write and a status read can occur in the same cycle. Read data is combinational from the current register state. Reading the status register clears it at the following clock edge.

Top module: `keyed_wp_unit`

## Requirements
- R1: After reset, protection is off, the status register reads zero and the control register reads zero.
- R2: The protect-enable bit takes the value of write-data bit 0 only when a write to offset 0xE4 has the key 0x4D4349 in write-data bits 31:8. With any other key, the bit keeps its value.
- R3: A read of offset 0xE4 returns the enable in bit 0 and zero in bits 31:1, so the key field always reads as zero.
- R4: For a write to a register outside the protected set, `wr_allow` shows a single set bit at index `wr_addr[7:2]` in the same cycle, whether protection is on or off.
- R5: While protection is on, a write to a protected offset leaves `wr_allow` all zero. The default protected offsets are 0x04, 0x08, 0x0C, 0x1C, 0x50 and 0x54.
- R6: A refused write sets bit 0 of the status register (offset 0xE8) and loads the target byte offset into bits 23:8. A later refusal overwrites the offset with its own.
- R7: A status read returns the logged value and clears both the flag and the offset from the next cycle.
- R8: A refused write in the same cycle as a status read is kept, so the next status read shows it.
- R9: Writes to 0xE4 and 0xE8 never raise `wr_allow`, and a write to 0xE8 leaves the status unchanged.
- R10: Turning protection off also needs the key, and after that, writes to protected offsets are allowed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W (8) | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W (8) | Read byte offset |
| rd_data | output | 32 | Read data for 0xE4 and 0xE8; zero elsewhere or when idle |
| wr_allow | output | NWORDS (64) | One-hot write enable per register word |

## Verification
The bench targets the key gate in both directions, using near-miss keys while protection is off and while it is on. A design that compared only part of the key, or that honoured bit 0 without the key, would flip the enable and show it on readback.

It collides a refused write with a status read in the same cycle. A design that let the clear win would lose that violation on the next read.

It also checks that a second refusal replaces the logged offset, that the guard's own two offsets never leak a write-allow pulse, and that unprotected registers stay writable while protection is on. A decoder that protected every register, or none, fails these checks at once.

// File: rtl/wp_pkg.sv
// Package: shared constants for the keyed write guard.
// Assumes byte offsets that fit in the block's address width (8 bits or more).
package wp_pkg;
    localparam int          DATA_W   = 32;
    localparam int          KEY_W    = 24;
    localparam int          SRC_W    = 16;
    localparam logic [23:0] GUARD_KEY = 24'h4D4349;
    localparam int          CTRL_OFS = 32'hE4;
    localparam int          STAT_OFS = 32'hE8;
endpackage

// File: rtl/wp_addr_decode.sv
// Module: wp_addr_decode
// Decodes a write byte offset into a one-hot word select and flags whether it
// hits the protected list, the guard control register or the guard status register.
// Assumes word-aligned offsets; the word select ignores addr[1:0].
module wp_addr_decode #(
    parameter int ADDR_W   = 8,
    parameter int NWORDS   = 64,
    parameter int NUM_PROT = 6,
    parameter int PROT_OFS [NUM_PROT] = '{32'h04, 32'h08, 32'h0C, 32'h1C, 32'h50, 32'h54}
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NWORDS-1:0] word_sel,
    output logic              hit_prot,
    output logic              hit_ctrl,
    output logic              hit_stat
);
    import wp_pkg::*;
    localparam int WIDX_W = ADDR_W - 2;

    logic [NUM_PROT-1:0] prot_match;

    // One select line per register word.
    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        assign word_sel[g] = (addr[ADDR_W-1:2] == WIDX_W'(g));
    end

    // One comparator per protected offset.
    for (genvar p = 0; p < NUM_PROT; p++) begin : g_prot
        assign prot_match[p] = (addr == ADDR_W'(PROT_OFS[p]));
    end

    assign hit_prot = |prot_match;
    assign hit_ctrl = (addr == ADDR_W'(CTRL_OFS));
    assign hit_stat = (addr == ADDR_W'(STAT_OFS));
endmodule

// File: rtl/wp_ctrl_reg.sv
// Module: wp_ctrl_reg
// Holds the protect-enable bit. It updates only on a control-register write
// whose upper 24 bits equal the guard key.
module wp_ctrl_reg (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic [23:0] key_in,
    input  logic        en_in,
    output logic        prot_en
);
    import wp_pkg::*;

    // Keyed update of the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prot_en <= 1'b0;
        else if (ctrl_wr && (key_in == GUARD_KEY))
            prot_en <= en_in;
    end
endmodule

// File: rtl/wp_viol_log.sv
// Module: wp_viol_log
// Records the most recent refused write. A new refusal takes priority over a
// clear-on-read in the same cycle, so no event is lost.
module wp_viol_log #(
    parameter int SRC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refuse,
    input  logic [SRC_W-1:0] refuse_ofs,
    input  logic             clear_rd,
    output logic             viol_flag,
    output logic [SRC_W-1:0] viol_src
);
    // Log with refusal over clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_flag <= 1'b0;
            viol_src  <= '0;
        end else if (refuse) begin
            viol_flag <= 1'b1;
            viol_src  <= refuse_ofs;
        end else if (clear_rd) begin
            viol_flag <= 1'b0;
            viol_src  <= '0;
        end
    end
endmodule

// File: rtl/keyed_wp_unit.sv
// Module: keyed_wp_unit (top)
// Write guard for a peripheral's register bank. It produces a one-hot write
// allow per register word, refuses writes to protected offsets while the
// keyed enable is set, and logs each refusal.
// Assumes 8 <= ADDR_W <= 16 and that the read and write channels are independent.
module keyed_wp_unit #(
    parameter int ADDR_W   = 8,
    parameter int NUM_PROT = 6,
    parameter int PROT_OFS [NUM_PROT] = '{32'h04, 32'h08, 32'h0C, 32'h1C, 32'h50, 32'h54},
    localparam int NWORDS  = 2 ** (ADDR_W - 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic [NWORDS-1:0] wr_allow
);
    import wp_pkg::*;

    logic [NWORDS-1:0] word_sel;
    logic              hit_prot, hit_ctrl, hit_stat;
    logic              prot_en;
    logic              refuse;
    logic              stat_rd;
    logic              viol_flag;
    logic [SRC_W-1:0]  viol_src;
    logic              unused_wdata;

    assign unused_wdata = ^wr_data[7:1];

    wp_addr_decode #(
        .ADDR_W(ADDR_W), .NWORDS(NWORDS), .NUM_PROT(NUM_PROT), .PROT_OFS(PROT_OFS)
    ) u_dec (
        .addr(wr_addr), .word_sel(word_sel),
        .hit_prot(hit_prot), .hit_ctrl(hit_ctrl), .hit_stat(hit_stat)
    );

    wp_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(wr_en && hit_ctrl),
        .key_in(wr_data[31:8]), .en_in(wr_data[0]),
        .prot_en(prot_en)
    );

    assign refuse  = wr_en && hit_prot && prot_en;
    assign stat_rd = rd_en && (rd_addr == ADDR_W'(STAT_OFS));

    wp_viol_log #(.SRC_W(SRC_W)) u_log (
        .clk(clk), .rst_n(rst_n),
        .refuse(refuse), .refuse_ofs(SRC_W'(wr_addr)),
        .clear_rd(stat_rd),
        .viol_flag(viol_flag), .viol_src(viol_src)
    );

    // Write-allow gating: refused writes and guard-owned offsets pass nothing.
    always_comb begin
        if (wr_en && !refuse && !hit_ctrl && !hit_stat)
            wr_allow = word_sel;
        else
            wr_allow = '0;
    end

    // Read mux for the two guard registers.
    always_comb begin
        rd_data = '0;
        if (rd_en && (rd_addr == ADDR_W'(CTRL_OFS)))
            rd_data = {31'd0, prot_en};
        else if (stat_rd)
            rd_data = {8'd0, viol_src, 7'd0, viol_flag};
    end
endmodule

// File: rtl/keyed_wp_unit_sva.sv
// Module: keyed_wp_unit_sva
// Checker bound to keyed_wp_unit. It watches the key gate, write-allow
// gating and the violation log.
module keyed_wp_unit_sva #(
    parameter int ADDR_W = 8,
    parameter int NWORDS = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [NWORDS-1:0] wr_allow,
    input logic              hit_prot,
    input logic              prot_en,
    input logic              viol_flag,
    input logic [15:0]       viol_src
);
    import wp_pkg::*;

    logic bad_key_wr, refused, status_rd, own_wr;
    assign bad_key_wr = wr_en && (wr_addr == ADDR_W'(CTRL_OFS)) && (wr_data[31:8] != GUARD_KEY);
    assign refused    = wr_en && hit_prot && prot_en;
    assign status_rd  = rd_en && (rd_addr == ADDR_W'(STAT_OFS));
    assign own_wr     = wr_en && ((wr_addr == ADDR_W'(CTRL_OFS)) || (wr_addr == ADDR_W'(STAT_OFS)));

    p_key_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bad_key_wr |=> $stable(prot_en));

    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_allow));

    p_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        refused |-> (wr_allow == '0));

    p_logged_r6: assert property (@(posedge clk) disable iff (!rst_n)
        refused |=> (viol_flag && (viol_src == 16'($past(wr_addr)))));

    p_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !refused) |=> (!viol_flag && (viol_src == '0)));

    p_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && refused) |=> viol_flag);

    p_own_regs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        own_wr |-> (wr_allow == '0));
endmodule

bind keyed_wp_unit keyed_wp_unit_sva #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_sva (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .wr_allow(wr_allow), .hit_prot(hit_prot),
    .prot_en(prot_en), .viol_flag(viol_flag), .viol_src(viol_src)
);

// File: tb/keyed_wp_unit_bench.sv
`timescale 1ns/1ps
// Directed bench for keyed_wp_unit: one task per scenario.
module keyed_wp_unit_bench;
    localparam logic [23:0] KEY = 24'h4D4349;
    localparam logic [7:0]  CTRL = 8'hE4;
    localparam logic [7:0]  STAT = 8'hE8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [63:0] wr_allow;

    int total = 0;
    int failed = 0;
    bit finished = 1'b0;

    keyed_wp_unit u_keyed_wp_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .wr_allow(wr_allow)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, sample combinational outputs, commit at the rising edge.
    task automatic cyc(input logic we, input logic [7:0] wa, input logic [31:0] wd,
                       input logic re, input logic [7:0] ra,
                       output logic [63:0] allow, output logic [31:0] rdat);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        #1;
        allow = wr_allow;
        rdat  = rd_data;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic [63:0] allow);
        logic [31:0] dummy;
        cyc(1'b1, a, d, 1'b0, 8'h00, allow, dummy);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        logic [63:0] dummy;
        cyc(1'b0, 8'h00, 32'h0, 1'b1, a, dummy, d);
    endtask

    function automatic logic [63:0] onehot(input logic [7:0] a);
        return 64'd1 << a[7:2];
    endfunction

    function automatic logic [31:0] stat_val(input logic [15:0] ofs);
        return {8'd0, ofs, 7'd0, 1'b1};
    endfunction

    task automatic t_reset;
        logic [31:0] d;
        rd(CTRL, d); check("R1 ctrl after reset", 64'(d), 64'h0);
        rd(STAT, d); check("R1 status after reset", 64'(d), 64'h0);
    endtask

    task automatic t_unprotected_pass;
        logic [63:0] a;
        wr(8'h04, 32'hAAAA_5555, a); check("R4 protected offset writable while off", a, onehot(8'h04));
        wr(8'h10, 32'h1234_5678, a); check("R4 argument offset writable", a, onehot(8'h10));
    endtask

    task automatic t_key_gate;
        logic [63:0] a; logic [31:0] d;
        wr(CTRL, {24'h4D4348, 8'h01}, a); rd(CTRL, d); check("R2 near-miss key ignored", 64'(d), 64'h0);
        wr(CTRL, {24'h000000, 8'hFF}, a); rd(CTRL, d); check("R2 zero key ignored", 64'(d), 64'h0);
        wr(CTRL, {KEY, 8'h01}, a); rd(CTRL, d); check("R3 enable readback, key reads zero", 64'(d), 64'h1);
        wr(CTRL, {24'hCD4349, 8'h00}, a); rd(CTRL, d); check("R2 wrong key cannot clear", 64'(d), 64'h1);
    endtask

    task automatic t_protected_block;
        logic [63:0] a; logic [31:0] d;
        logic [7:0] ofs [6] = '{8'h04, 8'h08, 8'h0C, 8'h1C, 8'h50, 8'h54};
        foreach (ofs[i]) begin
            wr(ofs[i], 32'hFFFF_FFFF, a);
            check("R5 protected write blocked", a, 64'h0);
        end
        wr(8'h10, 32'h1, a); check("R4 unprotected writable while on", a, onehot(8'h10));
        rd(STAT, d); check("R6 last refusal logged", 64'(d), 64'(stat_val(16'h0054)));
    endtask

    task automatic t_log_overwrite;
        logic [63:0] a; logic [31:0] d;
        wr(8'h08, 32'h0, a);
        wr(8'h1C, 32'h0, a);
        rd(STAT, d); check("R6 later refusal overwrites offset", 64'(d), 64'(stat_val(16'h001C)));
        rd(STAT, d); check("R7 status cleared by read", 64'(d), 64'h0);
    endtask

    task automatic t_same_cycle;
        logic [63:0] a; logic [31:0] d;
        wr(8'h0C, 32'h0, a);
        cyc(1'b1, 8'h50, 32'h0, 1'b1, STAT, a, d);
        check("R8 collision read returns prior log", 64'(d), 64'(stat_val(16'h000C)));
        check("R8 collision write blocked", a, 64'h0);
        rd(STAT, d); check("R8 refusal kept across read", 64'(d), 64'(stat_val(16'h0050)));
    endtask

    task automatic t_own_regs;
        logic [63:0] a; logic [31:0] d;
        wr(STAT, 32'hFFFF_FFFF, a); check("R9 status write no allow", a, 64'h0);
        rd(STAT, d); check("R9 status write ignored", 64'(d), 64'h0);
        wr(CTRL, {KEY, 8'h01}, a); check("R9 control write no allow", a, 64'h0);
    endtask

    task automatic t_disable;
        logic [63:0] a; logic [31:0] d;
        wr(CTRL, {KEY, 8'h00}, a); rd(CTRL, d); check("R10 keyed disable", 64'(d), 64'h0);
        wr(8'h54, 32'h7, a); check("R10 protected writable again", a, onehot(8'h54));
        rd(STAT, d); check("R10 no log when off", 64'(d), 64'h0);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unprotected_pass();
        t_key_gate();
        t_protected_block();
        t_log_overwrite();
        t_same_cycle();
        t_own_regs();
        t_disable();
        finished = 1'b1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            failed++;
            $display("FAIL watchdog: actual hung expected done");
            report();
        end
    end
endmodule